// File: doc/BRIEF.md
# Serial-Controlled Audio/Video Routing Register

This block is a receive-only two-wire serial slave. It accepts a three-byte write transaction and keeps two 8-bit control registers. It turns their contents into the digital select and enable lines of an analog routing matrix. On the video side it picks a composite source and a luma/chroma input pair, and it can switch to a luma/chroma mix. It also sets three amplifier gain flags. On the audio side it picks a stereo input pair and a channel-mapping mode (muted, both outputs from the right channel, both from the left, or normal stereo). It also drives one general-purpose output pin, with inverted polarity.

The serial clock and data lines are sampled by the system clock, resynchronized and edge-detected, so the whole block lives in one clock domain. The slave acknowledges by pulling the data line low through an open-drain enable output. One static pin supplies the lowest bit of the slave address, so two instances can share a bus. Reads, arbitration and clock stretching are not part of the block.

Top module: `av_route_ctrl`

## Requirements
- R1: The slave acknowledges the address byte (pulls the data line low during the ninth clock) when the byte is binary 1001_00A0, where A is `addr_sel_i`, and the last bit is 0 (write). This gives 0x90 with the pin low and 0x92 with the pin high.
- R2: Any other address byte, including one with the last bit 1, is not acknowledged. All bus activity that follows is ignored until the next START, and no output changes.
- R3: The first and second data bytes are each acknowledged, and each one is committed to its register at the end of its own acknowledge clock. A STOP or START that arrives before that point discards the byte in progress. Bytes committed earlier in the same transaction stay in effect.
- R4: A third or later data byte in one transaction is not acknowledged and has no effect on any output.
- R5: After reset both registers are zero. The outputs then show composite source 0, no mix, luma/chroma source 0, all gains 0, audio muted, audio source 0 and `gpo_o` high.
- R6: Bits of the first data byte set the gains: bit 5 sets `gain_sep_o`, bit 4 sets `gain_yc_o` and bit 3 sets `gain_vid_o`. A 1 means the +6 dB setting.
- R7: Bits 2..0 of the first data byte form the video code. `vid_src_o` equals bits 1..0 and `yc_mix_o` equals bit 2. `yc_src_o` equals bits 1..0 when bit 2 is 1, and is 0 (common inputs) otherwise.
- R8: Bits 15..14 (bits 7..6 of the second data byte) set the audio mode. Code 00 sets `aud_mute_o`. Code 01 sets `aud_l_use_r_o` (both outputs from the right channel). Code 10 sets `aud_r_use_l_o` (both outputs from the left channel). Code 11 clears all three (normal stereo).
- R9: Bits 9..8 (bits 1..0 of the second data byte) appear on `aud_src_o`.
- R10: `gpo_o` is the inverse of bit 10 (bit 2 of the second data byte).
- R11: `sda_pull_o` turns on only one cycle after a detected serial-clock falling edge. It turns off only after a falling edge, a START or a STOP, so the data line changes only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as sampled from the bus |
| sda_i | input | 1 | Serial data line as sampled from the bus |
| addr_sel_i | input | 1 | Static pin supplying the lowest slave address bit |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| vid_src_o | output | 2 | Composite source: 0 tuner, 1..3 inputs 2..4 |
| yc_mix_o | output | 1 | 1 sends the luma/chroma mix to the video output |
| yc_src_o | output | 2 | Luma/chroma input pair: 0 common, 1..3 inputs 2..4 |
| gain_vid_o | output | 1 | Video amplifier +6 dB |
| gain_yc_o | output | 1 | Luma/chroma amplifier +6 dB |
| gain_sep_o | output | 1 | Separator-path amplifier +6 dB |
| aud_mute_o | output | 1 | Audio outputs muted |
| aud_l_use_r_o | output | 1 | Left output takes the right channel |
| aud_r_use_l_o | output | 1 | Right output takes the left channel |
| aud_src_o | output | 2 | Audio input pair: 0 tuner, 1..3 inputs 2..4 |
| gpo_o | output | 1 | General-purpose pin, inverse of its control bit |

## Verification
The main sweep writes all 64 combinations of the live bits of the first data byte. Each time it varies the audio mode, the source and the pin bit alongside, so every video code is seen with every gain pattern, and every audio mode with every source. This separates a wrong bit position from a wrong code mapping. Address tests use both pin levels against both address values and the read bit, which separates a missing compare on the pin bit from a missing compare on the direction bit. Truncated transactions (STOP after one byte, STOP or START inside a byte, an extra third byte) separate per-byte commit from commit at the end of the message.

// File: rtl/av_route_pkg.sv
package av_route_pkg;

   // Upper six bits of the slave address; the pin supplies the seventh.
   localparam logic [5:0] ADDR_HI = 6'b100100;

   // Number of payload bytes in one transaction.
   localparam int NUM_DATA = 2;

   // Bits per byte on the bus.
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RECV,
      ST_ACK,
      ST_SKIP
   } slv_state_t;

   typedef enum logic [1:0] {
      AUD_MUTE   = 2'b00,
      AUD_RIGHT2 = 2'b01,
      AUD_LEFT2  = 2'b10,
      AUD_STEREO = 2'b11
   } aud_mode_t;

endpackage

// File: rtl/av_bus_sync.sv
module av_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("av_bus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_s;
   logic              scl_q;
   logic              sda_q;

   // Synchronizer chain; idle bus level is high, so reset to ones.
   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_pipe[0] <= 1'b1;
                  sda_pipe[0] <= 1'b1;
               end else begin
                  scl_pipe[0] <= scl_i;
                  sda_pipe[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_pipe[gi] <= 1'b1;
                  sda_pipe[gi] <= 1'b1;
               end else begin
                  scl_pipe[gi] <= scl_pipe[gi-1];
                  sda_pipe[gi] <= sda_pipe[gi-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/av_i2c_wr_slave.sv
module av_i2c_wr_slave
   import av_route_pkg::*;
#(
   parameter int N_BYTES = NUM_DATA,
   parameter int BW      = BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              addr_lsb,
   output logic              sda_pull,
   output logic [N_BYTES*BW-1:0] ctrl_flat
);

   localparam int IDXW = $clog2(N_BYTES + 2);
   localparam int CNTW = $clog2(BW + 1);

   generate
      if (BW != 8) begin : g_bad_bw
         $error("av_i2c_wr_slave: bus bytes are 8 bits");
      end
      if (N_BYTES < 1) begin : g_bad_n
         $error("av_i2c_wr_slave: need at least one payload byte");
      end
   endgenerate

   slv_state_t       st;
   logic [BW-1:0]    shreg;
   logic [CNTW-1:0]  bit_cnt;
   logic [IDXW-1:0]  byte_idx;
   logic             byte_done;
   logic             accept;
   logic             ack_end;

   assign byte_done = (bit_cnt == CNTW'(BW));

   // Address byte: fixed upper bits, pin bit, write direction.
   always_comb begin
      if (byte_idx == '0) begin
         accept = (shreg == {ADDR_HI, addr_lsb, 1'b0});
      end else begin
         accept = (byte_idx <= IDXW'(N_BYTES));
      end
   end

   assign ack_end = (st == ST_ACK) && scl_fall && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         shreg    <= '0;
         bit_cnt  <= '0;
         byte_idx <= '0;
         sda_pull <= 1'b0;
      end else if (start_det) begin
         st       <= ST_RECV;
         bit_cnt  <= '0;
         byte_idx <= '0;
         sda_pull <= 1'b0;
      end else if (stop_det) begin
         st       <= ST_IDLE;
         sda_pull <= 1'b0;
      end else begin
         case (st)
            ST_RECV: begin
               if (scl_rise && !byte_done) begin
                  shreg   <= {shreg[BW-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall && byte_done) begin
                  if (accept) begin
                     sda_pull <= 1'b1;
                     st       <= ST_ACK;
                  end else begin
                     st       <= ST_SKIP;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  bit_cnt  <= '0;
                  byte_idx <= byte_idx + 1'b1;
                  st       <= ST_RECV;
               end
            end
            default: begin
               // idle or ignoring the rest of the transaction
            end
         endcase
      end
   end

   // One register per payload byte, written at the end of its own ACK.
   generate
      genvar gk;
      for (gk = 0; gk < N_BYTES; gk++) begin : g_reg
         logic wr_en;
         assign wr_en = ack_end && (byte_idx == IDXW'(gk + 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctrl_flat[gk*BW +: BW] <= '0;
            end else if (wr_en) begin
               ctrl_flat[gk*BW +: BW] <= shreg;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/av_route_decode.sv
module av_route_decode
   import av_route_pkg::*;
#(
   parameter bit GPO_INVERT = 1'b1,
   parameter int SEL_W      = 2
) (
   input  logic [5:0]       vid_byte,
   input  logic [1:0]       aud_mode,
   input  logic             gpo_bit,
   input  logic [SEL_W-1:0] aud_sel,
   output logic [SEL_W-1:0] vid_src,
   output logic             yc_mix,
   output logic [SEL_W-1:0] yc_src,
   output logic             gain_vid,
   output logic             gain_yc,
   output logic             gain_sep,
   output logic             aud_mute,
   output logic             aud_l_use_r,
   output logic             aud_r_use_l,
   output logic [SEL_W-1:0] aud_src,
   output logic             gpo
);

   generate
      if (SEL_W != 2) begin : g_bad_sel
         $error("av_route_decode: four-way selects need SEL_W of 2");
      end
   endgenerate

   aud_mode_t mode;
   assign mode = aud_mode_t'(aud_mode);

   // Video: low code bits pick the input, top bit picks the mix path.
   always_comb begin
      vid_src = vid_byte[1:0];
      yc_mix  = vid_byte[2];
      yc_src  = vid_byte[2] ? vid_byte[1:0] : '0;
   end

   assign gain_vid = vid_byte[3];
   assign gain_yc  = vid_byte[4];
   assign gain_sep = vid_byte[5];

   always_comb begin
      aud_mute    = 1'b0;
      aud_l_use_r = 1'b0;
      aud_r_use_l = 1'b0;
      case (mode)
         AUD_MUTE:   aud_mute    = 1'b1;
         AUD_RIGHT2: aud_l_use_r = 1'b1;
         AUD_LEFT2:  aud_r_use_l = 1'b1;
         default:    ;
      endcase
   end

   assign aud_src = aud_sel;

   generate
      if (GPO_INVERT) begin : g_gpo_inv
         assign gpo = ~gpo_bit;
      end else begin : g_gpo_pass
         assign gpo = gpo_bit;
      end
   endgenerate

endmodule

// File: rtl/av_route_ctrl.sv
module av_route_ctrl
   import av_route_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit GPO_INVERT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       addr_sel_i,
   output logic       sda_pull_o,
   output logic [1:0] vid_src_o,
   output logic       yc_mix_o,
   output logic [1:0] yc_src_o,
   output logic       gain_vid_o,
   output logic       gain_yc_o,
   output logic       gain_sep_o,
   output logic       aud_mute_o,
   output logic       aud_l_use_r_o,
   output logic       aud_r_use_l_o,
   output logic [1:0] aud_src_o,
   output logic       gpo_o
);

   localparam int FLAT_W = NUM_DATA * BYTE_W;

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [FLAT_W-1:0] ctrl_flat;
   logic              unused_fixed;

   av_bus_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   av_i2c_wr_slave #(
      .N_BYTES (NUM_DATA),
      .BW      (BYTE_W)
   ) u_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_lsb  (addr_sel_i),
      .sda_pull  (sda_pull_o),
      .ctrl_flat (ctrl_flat)
   );

   // Bits fixed at zero by the message format carry no function.
   assign unused_fixed = ^{ctrl_flat[13:11], ctrl_flat[7:6]};

   av_route_decode #(
      .GPO_INVERT (GPO_INVERT),
      .SEL_W      (2)
   ) u_decode (
      .vid_byte    (ctrl_flat[5:0]),
      .aud_mode    (ctrl_flat[15:14]),
      .gpo_bit     (ctrl_flat[10]),
      .aud_sel     (ctrl_flat[9:8]),
      .vid_src     (vid_src_o),
      .yc_mix      (yc_mix_o),
      .yc_src      (yc_src_o),
      .gain_vid    (gain_vid_o),
      .gain_yc     (gain_yc_o),
      .gain_sep    (gain_sep_o),
      .aud_mute    (aud_mute_o),
      .aud_l_use_r (aud_l_use_r_o),
      .aud_r_use_l (aud_r_use_l_o),
      .aud_src     (aud_src_o),
      .gpo         (gpo_o)
   );

endmodule

// File: rtl/av_route_chk.sv
module av_route_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_fall,
   input logic        start_det,
   input logic        stop_det,
   input logic [15:0] ctrl_flat,
   input logic        sda_pull_o,
   input logic [1:0]  vid_src_o,
   input logic        yc_mix_o,
   input logic [1:0]  yc_src_o,
   input logic        aud_mute_o,
   input logic        aud_l_use_r_o,
   input logic        aud_r_use_l_o
);

   // R11: pull-down only starts right after a serial clock fall
   a_r11_pull_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(scl_fall));

   // R11: pull-down released only on a fall, START or STOP
   a_r11_pull_off: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> $past(scl_fall || start_det || stop_det));

   // R3: registers change only at the end of an acknowledge clock
   a_r3_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_flat) |-> $past(scl_fall));

   // R7: without mixing the luma/chroma path uses the common inputs
   a_r7_common_yc: assert property (@(posedge clk) disable iff (!rst_n)
      !yc_mix_o |-> (yc_src_o == 2'd0));

   // R7: with mixing the luma/chroma pair follows the selected input
   a_r7_mix_follow: assert property (@(posedge clk) disable iff (!rst_n)
      yc_mix_o |-> (yc_src_o == vid_src_o));

   // R8: audio mode flags are mutually exclusive
   a_r8_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({aud_mute_o, aud_l_use_r_o, aud_r_use_l_o}));

endmodule

bind av_route_ctrl av_route_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_fall      (scl_fall),
   .start_det     (start_det),
   .stop_det      (stop_det),
   .ctrl_flat     (ctrl_flat),
   .sda_pull_o    (sda_pull_o),
   .vid_src_o     (vid_src_o),
   .yc_mix_o      (yc_mix_o),
   .yc_src_o      (yc_src_o),
   .aud_mute_o    (aud_mute_o),
   .aud_l_use_r_o (aud_l_use_r_o),
   .aud_r_use_l_o (aud_r_use_l_o)
);

// File: tb/test_av_route_ctrl.sv
`timescale 1ns/1ps
module test_av_route_ctrl;

   localparam int Q = 10;   // system cycles per quarter serial period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_drv = 1'b1;
   logic addr_sel = 1'b0;
   logic sda_line;

   logic       sda_pull_o;
   logic [1:0] vid_src_o, yc_src_o, aud_src_o;
   logic       yc_mix_o, gain_vid_o, gain_yc_o, gain_sep_o;
   logic       aud_mute_o, aud_l_use_r_o, aud_r_use_l_o, gpo_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_d1 = 8'h00;
   logic [7:0] exp_d2 = 8'h00;

   always #5 clk = ~clk;

   assign sda_line = sda_drv & ~sda_pull_o;

   av_route_ctrl i_av_route_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl),
      .sda_i         (sda_line),
      .addr_sel_i    (addr_sel),
      .sda_pull_o    (sda_pull_o),
      .vid_src_o     (vid_src_o),
      .yc_mix_o      (yc_mix_o),
      .yc_src_o      (yc_src_o),
      .gain_vid_o    (gain_vid_o),
      .gain_yc_o     (gain_yc_o),
      .gain_sep_o    (gain_sep_o),
      .aud_mute_o    (aud_mute_o),
      .aud_l_use_r_o (aud_l_use_r_o),
      .aud_r_use_l_o (aud_r_use_l_o),
      .aud_src_o     (aud_src_o),
      .gpo_o         (gpo_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic qwait(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; qwait(1);
      scl = 1'b1;     qwait(1);
      sda_drv = 1'b0; qwait(1);
      scl = 1'b0;     qwait(1);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; qwait(1);
      scl = 1'b1;     qwait(1);
      sda_drv = 1'b1; qwait(2);
   endtask

   task automatic send_bit(input logic b);
      sda_drv = b; qwait(1);
      scl = 1'b1;  qwait(2);
      scl = 1'b0;  qwait(1);
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      send_bits(v, 8);
      sda_drv = 1'b1; qwait(1);
      scl = 1'b1;     qwait(1);
      ack = ~sda_line; qwait(1);
      scl = 1'b0;     qwait(1);
   endtask

   task automatic write_msg(input logic [7:0] a, input logic [7:0] d1,
                            input logic [7:0] d2, output logic [2:0] acks);
      bus_start();
      send_byte(a, acks[2]);
      send_byte(d1, acks[1]);
      send_byte(d2, acks[0]);
      bus_stop();
   endtask

   task automatic check_outputs(input string tag);
      logic [15:0] act, exp;
      logic [1:0] m;
      m = exp_d2[7:6];
      exp = {exp_d1[1:0], exp_d1[2], (exp_d1[2] ? exp_d1[1:0] : 2'b00),
             exp_d1[3], exp_d1[4], exp_d1[5],
             (m == 2'd0), (m == 2'd1), (m == 2'd2),
             exp_d2[1:0], ~exp_d2[2], 1'b0};
      act = {vid_src_o, yc_mix_o, yc_src_o, gain_vid_o, gain_yc_o, gain_sep_o,
             aud_mute_o, aud_l_use_r_o, aud_r_use_l_o, aud_src_o, gpo_o, sda_pull_o};
      check(act == exp, tag, int'(act), int'(exp));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [2:0] acks;
      logic       a;
      logic [7:0] d1, d2;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R5: reset values
      check_outputs("R5 reset state");

      // Sweep: every live bit pattern of DATA1, audio fields alongside
      for (int i = 0; i < 64; i++) begin
         d1 = {2'b00, 6'(i)};
         d2 = {2'(i), 3'b000, 1'(i >> 2), 2'(i >> 3)};
         write_msg(8'h90, d1, d2, acks);
         check(acks == 3'b111, "R1 R3 acks on 0x90", int'(acks), 7);
         exp_d1 = d1; exp_d2 = d2;
         check_outputs("R6 R7 R8 R9 R10 sweep");
      end

      // R1: pin high moves address to 0x92
      addr_sel = 1'b1;
      write_msg(8'h92, 8'h2D, 8'h81, acks);
      check(acks == 3'b111, "R1 acks on 0x92", int'(acks), 7);
      exp_d1 = 8'h2D; exp_d2 = 8'h81;
      check_outputs("R1 write via 0x92");

      // R2: 0x90 rejected while pin high
      write_msg(8'h90, 8'h07, 8'h40, acks);
      check(acks[2] == 1'b0, "R2 nack 0x90 with pin high", int'(acks[2]), 0);
      check(acks[1:0] == 2'b00, "R2 later bytes ignored", int'(acks[1:0]), 0);
      check_outputs("R2 outputs unchanged after mismatch");

      // R2: read direction rejected
      write_msg(8'h93, 8'h3F, 8'hC7, acks);
      check(acks == 3'b000, "R2 nack read bit", int'(acks), 0);
      check_outputs("R2 outputs unchanged after read bit");

      addr_sel = 1'b0;
      write_msg(8'h92, 8'h11, 8'h42, acks);
      check(acks == 3'b000, "R2 nack 0x92 with pin low", int'(acks), 0);
      check_outputs("R2 outputs unchanged, pin low");

      // R3: STOP after first byte keeps it, second untouched
      bus_start();
      send_byte(8'h90, a);
      send_byte(8'h1E, a);
      check(a == 1'b1, "R3 first byte acked", int'(a), 1);
      bus_stop();
      exp_d1 = 8'h1E;
      check_outputs("R3 first byte committed alone");

      // R3: STOP inside a byte discards it
      bus_start();
      send_byte(8'h90, a);
      send_bits(8'h05, 4);
      bus_stop();
      check_outputs("R3 partial byte dropped on STOP");

      // R3: repeated START inside a byte, then a full message
      bus_start();
      send_byte(8'h90, a);
      send_byte(8'h2A, a);
      send_bits(8'hFF, 3);
      bus_start();
      send_byte(8'h90, a);
      send_byte(8'h0C, a);
      send_byte(8'h46, a);
      bus_stop();
      exp_d1 = 8'h0C; exp_d2 = 8'h46;
      check_outputs("R3 repeated START restarts message");

      // R4: third data byte refused and without effect
      bus_start();
      send_byte(8'h90, a);
      send_byte(8'h33, a);
      send_byte(8'hC3, a);
      check(a == 1'b1, "R4 second byte still acked", int'(a), 1);
      send_byte(8'h00, a);
      check(a == 1'b0, "R4 third byte nacked", int'(a), 0);
      bus_stop();
      exp_d1 = 8'h33; exp_d2 = 8'hC3;
      check_outputs("R4 third byte no effect");

      // R11: line released while idle
      qwait(2);
      check(sda_pull_o == 1'b0, "R11 pull released when idle", int'(sda_pull_o), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule